// File: doc/BRIEF.md
# Inbound Transaction Ordering Queue

This block holds up to eight inbound bus transactions and hands them to a downstream port one at a time. The order is not first-in first-out. A fixed pass table decides which transaction may overtake an older one. Each transaction has a class and an opaque tag. The queue does nothing with the tag except carry it through.

The downstream side gives one ready bit per class. When one class is stalled, a younger transaction of another class may go around it, as long as the pass table allows that against every older entry still waiting. On each cycle the queue issues the oldest entry that both has its class ready downstream and may pass every older pending entry. That entry is removed, and the entries behind it close the gap without changing their relative age.

A mode input selects conventional or extended bus operation. The mode only decides which kind of read request the input accepts. The block has no ordering-relaxation input, so nothing can loosen the table.

Top module: `inbound_order_q`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0 and `out_valid`=0.
- R2: Class codes are posted write=0, delayed read=1, split read=2, configuration write=3 and read completion=4. Posted writes issue strictly in arrival order. No entry of any class issues while an older posted write is pending.
- R3: A posted write may overtake older pending entries of classes 1, 2, 3 and 4.
- R4: A delayed read or split read may overtake only older read completions (class 4). It waits behind older reads and behind an older configuration write.
- R5: A configuration write may overtake only older read completions. It waits behind older delayed or split reads.
- R6: A read completion may overtake older entries of classes 1, 2, 3 and 4. It never overtakes an older posted write.
- R7: A delayed read (class 1) is accepted only when `mode_ext`=0. A split read (class 2) is accepted only when `mode_ext`=1. Class codes 5 to 7 are never accepted. A refused input sees `in_ready`=0.
- R8: At most one configuration write is held. While one is pending, a new class-3 input sees `in_ready`=0, including in the cycle the held one issues.
- R9: Bit k of `dn_ready` is the downstream ready for class k. `out_valid` is 1 only in a cycle where an entry issues. That entry is the oldest whose class is ready and which may overtake every older pending entry.
- R10: The queue holds 8 entries. `full` is 1 at 8 entries and then `in_ready`=0. Removing an entry from the middle keeps the remaining entries in age order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ext | input | 1 | 0 = conventional mode, 1 = extended mode |
| in_valid | input | 1 | Input transaction present |
| in_cls | input | 3 | Class code of the input transaction |
| in_tag | input | TAG_W | Opaque tag of the input transaction |
| in_ready | output | 1 | Input transaction is taken this cycle when in_valid=1 |
| dn_ready | input | 5 | Downstream ready, one bit per class |
| out_valid | output | 1 | An entry issues this cycle |
| out_cls | output | 3 | Class code of the issued entry |
| out_tag | output | TAG_W | Tag of the issued entry |
| full | output | 1 | Queue holds 8 entries |
| empty | output | 1 | Queue holds no entries |

## Verification
The assertions need `rst_n` held low through the first clock edge. They also rely on an entry being taken only when `in_valid` and `in_ready` are both high. The stimulus may therefore present refused transactions freely, including illegal class codes and read classes in the wrong mode. It may also drop `in_valid` at any time, since the queue keeps nothing on refusal. Directed phases set up each overtaking case with downstream readiness held low while the queue fills. Random traffic then mixes modes, class codes and readiness patterns.

// File: rtl/ordq_pkg.sv
package ordq_pkg;

  localparam int NCLS     = 5;
  localparam int CLS_W    = 3;
  localparam int CLS_SPAN = 1 << CLS_W;

  typedef enum logic [CLS_W-1:0] {
    CLS_PW  = 3'd0,
    CLS_DRD = 3'd1,
    CLS_SRD = 3'd2,
    CLS_CFG = 3'd3,
    CLS_CPL = 3'd4
  } cls_e;

  // young may overtake old?
  function automatic logic may_pass(logic [CLS_W-1:0] young, logic [CLS_W-1:0] old);
    logic ok;
    ok = 1'b0;
    case (cls_e'(young))
      CLS_PW, CLS_CPL:          ok = (cls_e'(old) != CLS_PW);
      CLS_DRD, CLS_SRD, CLS_CFG: ok = (cls_e'(old) == CLS_CPL);
      default:                  ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/ordq_store.sv
module ordq_store
  import ordq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push,
  input  logic [CLS_W-1:0]                 push_cls,
  input  logic [TAG_W-1:0]                 push_tag,
  input  logic                             pop,
  input  logic [IDX_W-1:0]                 pop_idx,
  output logic [DEPTH-1:0]                 ent_vld,
  output logic [DEPTH-1:0][CLS_W-1:0]      ent_cls,
  output logic [DEPTH-1:0][TAG_W-1:0]      ent_tag,
  output logic [CNT_W-1:0]                 count
);

  logic [DEPTH-1:0][CLS_W-1:0] cls_q, cls_n;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q, tag_n;
  logic [CNT_W-1:0]            cnt_q, cnt_n;
  logic                        upd_en;

  assign upd_en = push | pop;

  // next state: compact out the popped slot, then append at the tail
  always_comb begin
    cls_n = cls_q;
    tag_n = tag_q;
    cnt_n = cnt_q;
    if (pop) begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        if (IDX_W'(k) >= pop_idx) begin
          cls_n[k] = cls_q[k+1];
          tag_n[k] = tag_q[k+1];
        end
      end
      cnt_n = cnt_q - 1'b1;
    end
    if (push) begin
      cls_n[cnt_n[IDX_W-1:0]] = push_cls;
      tag_n[cnt_n[IDX_W-1:0]] = push_tag;
      cnt_n = cnt_n + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (upd_en)
      cnt_q <= cnt_n;
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      cls_q <= cls_n;
      tag_q <= tag_n;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_vld
    assign ent_vld[g] = (CNT_W'(g) < cnt_q);
  end

  assign ent_cls = cls_q;
  assign ent_tag = tag_q;
  assign count   = cnt_q;

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CNT_W'(DEPTH)));

  assert_pop_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (CNT_W'(pop_idx) < cnt_q));

endmodule

// File: rtl/ordq_pick.sv
module ordq_pick
  import ordq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]            ent_vld,
  input  logic [DEPTH-1:0][CLS_W-1:0] ent_cls,
  input  logic [NCLS-1:0]             dn_ready,
  output logic                        sel_vld,
  output logic [IDX_W-1:0]            sel_idx
);

  logic [CLS_SPAN-1:0] rdy_ext;
  logic [DEPTH-1:0]    elig;

  assign rdy_ext = CLS_SPAN'(dn_ready);

  // eligible: class ready downstream and allowed past every older entry
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      elig[i] = ent_vld[i] & rdy_ext[ent_cls[i]];
      for (int j = 0; j < i; j++) begin
        if (ent_vld[j] && !may_pass(ent_cls[i], ent_cls[j]))
          elig[i] = 1'b0;
      end
    end
  end

  // oldest eligible wins (slot 0 is oldest)
  always_comb begin
    sel_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (elig[i])
        sel_idx = IDX_W'(i);
    end
  end

  assign sel_vld = |elig;

endmodule

// File: rtl/inbound_order_q.sv
module inbound_order_q
  import ordq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_ext,
  input  logic             in_valid,
  input  logic [2:0]       in_cls,
  input  logic [TAG_W-1:0] in_tag,
  output logic             in_ready,
  input  logic [4:0]       dn_ready,
  output logic             out_valid,
  output logic [2:0]       out_cls,
  output logic [TAG_W-1:0] out_tag,
  output logic             full,
  output logic             empty
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]            ent_vld;
  logic [DEPTH-1:0][CLS_W-1:0] ent_cls;
  logic [DEPTH-1:0][TAG_W-1:0] ent_tag;
  logic [CNT_W-1:0]            count;
  logic                        sel_vld;
  logic [IDX_W-1:0]            sel_idx;
  logic [DEPTH-1:0]            cfg_mask, pw_mask, cpl_mask, older;
  logic                        cfg_held, cls_legal, push;
  logic [CLS_SPAN-1:0]         rdy_ext;

  for (genvar g = 0; g < DEPTH; g++) begin : g_mask
    assign cfg_mask[g] = ent_vld[g] & (ent_cls[g] == CLS_CFG);
    assign pw_mask[g]  = ent_vld[g] & (ent_cls[g] == CLS_PW);
    assign cpl_mask[g] = ent_vld[g] & (ent_cls[g] == CLS_CPL);
    assign older[g]    = ent_vld[g] & (IDX_W'(g) < sel_idx);
  end

  assign cfg_held = |cfg_mask;

  always_comb begin
    case (in_cls)
      CLS_PW, CLS_CPL: cls_legal = 1'b1;
      CLS_CFG:         cls_legal = !cfg_held;
      CLS_DRD:         cls_legal = !mode_ext;
      CLS_SRD:         cls_legal = mode_ext;
      default:         cls_legal = 1'b0;
    endcase
  end

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign in_ready = !full && cls_legal;
  assign push     = in_valid && in_ready;

  ordq_store #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_cls (in_cls),
    .push_tag (in_tag),
    .pop      (sel_vld),
    .pop_idx  (sel_idx),
    .ent_vld  (ent_vld),
    .ent_cls  (ent_cls),
    .ent_tag  (ent_tag),
    .count    (count)
  );

  ordq_pick #(.DEPTH(DEPTH)) u_pick (
    .ent_vld  (ent_vld),
    .ent_cls  (ent_cls),
    .dn_ready (dn_ready),
    .sel_vld  (sel_vld),
    .sel_idx  (sel_idx)
  );

  assign out_valid = sel_vld;
  assign out_cls   = ent_cls[sel_idx];
  assign out_tag   = ent_tag[sel_idx];
  assign rdy_ext   = CLS_SPAN'(dn_ready);

  assert_no_pass_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((older & pw_mask) == '0));

  assert_req_behind_cpl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_cls == CLS_DRD || out_cls == CLS_SRD || out_cls == CLS_CFG))
      |-> ((older & ~cpl_mask) == '0));

  assert_single_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cfg_mask) <= 1);

  assert_issue_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> rdy_ext[out_cls]);

  assert_full_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> (count == CNT_W'(DEPTH)) || $past(out_valid));

endmodule

// File: tb/inbound_order_q_bench.sv
module inbound_order_q_bench;

  localparam int DEPTH = 8;
  localparam int PW = 0, DRD = 1, SRD = 2, CFG = 3, CPL = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_ext, in_valid, in_ready, out_valid, full, empty;
  logic [2:0] in_cls, out_cls;
  logic [7:0] in_tag, out_tag;
  logic [4:0] dn_ready;

  int    total = 0;
  int    bad   = 0;
  string cur_req = "R1";

  typedef struct { int c; int t; } ent_t;
  ent_t q[$];

  always #5 clk = ~clk;

  inbound_order_q #(.DEPTH(DEPTH), .TAG_W(8)) u_inbound_order_q (
    .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .in_valid(in_valid),
    .in_cls(in_cls), .in_tag(in_tag), .in_ready(in_ready), .dn_ready(dn_ready),
    .out_valid(out_valid), .out_cls(out_cls), .out_tag(out_tag),
    .full(full), .empty(empty)
  );

  // pass table from the requirements: may 'y' overtake an older 'o'?
  function automatic bit passes(int y, int o);
    if (o == PW) return 1'b0;
    if (y == PW || y == CPL) return 1'b1;
    return (o == CPL);
  endfunction

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic step(bit v, int c, int t, bit m, logic [4:0] r);
    bit exp_rdy, legal, has_cfg;
    int pk;
    @(negedge clk);
    in_valid = v; in_cls = 3'(c); in_tag = 8'(t); mode_ext = m; dn_ready = r;
    #1;
    has_cfg = 1'b0;
    foreach (q[i]) if (q[i].c == CFG) has_cfg = 1'b1;
    case (c)
      PW, CPL: legal = 1'b1;
      CFG:     legal = !has_cfg;
      DRD:     legal = !m;
      SRD:     legal = m;
      default: legal = 1'b0;
    endcase
    exp_rdy = (q.size() < DEPTH) && legal;
    pk = -1;
    for (int i = 0; i < q.size() && pk < 0; i++) begin
      bit ok;
      ok = r[q[i].c];
      for (int j = 0; j < i; j++) if (!passes(q[i].c, q[j].c)) ok = 1'b0;
      if (ok) pk = i;
    end
    chk("in_ready", int'(in_ready), int'(exp_rdy));
    chk("full", int'(full), int'(q.size() == DEPTH));
    chk("empty", int'(empty), int'(q.size() == 0));
    chk("out_valid", int'(out_valid), int'(pk >= 0));
    if (pk >= 0) begin
      chk("out_cls", int'(out_cls), q[pk].c);
      chk("out_tag", int'(out_tag), q[pk].t);
    end
    @(posedge clk);
    if (pk >= 0) q.delete(pk);
    if (v && exp_rdy) q.push_back('{c, t});
  endtask

  task automatic push(int c, int t, bit m);
    step(1'b1, c, t, m, 5'b0);
  endtask

  task automatic drain();
    repeat (10) step(1'b0, 0, 0, 1'b0, 5'h1f);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_cls = '0; in_tag = '0; mode_ext = 1'b0; dn_ready = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    cur_req = "R1";
    repeat (2) step(1'b0, 0, 0, 1'b0, 5'h1f);

    cur_req = "R2";
    push(PW, 1, 0); push(PW, 2, 0); push(CPL, 3, 0);
    repeat (2) step(1'b0, 0, 0, 1'b0, 5'b10000);
    drain();

    cur_req = "R3";
    push(DRD, 10, 0); push(CFG, 11, 0); push(PW, 12, 0);
    step(1'b0, 0, 0, 1'b0, 5'b00001);
    drain();

    cur_req = "R4";
    push(CPL, 20, 0); push(DRD, 21, 0); push(DRD, 22, 0);
    repeat (3) step(1'b0, 0, 0, 1'b0, 5'b00010);
    push(CFG, 23, 0); push(DRD, 24, 0);
    repeat (2) step(1'b0, 0, 0, 1'b0, 5'b00010);
    drain();

    cur_req = "R5";
    push(DRD, 30, 0); push(CFG, 31, 0);
    repeat (2) step(1'b0, 0, 0, 1'b0, 5'b01000);
    drain();
    push(CPL, 32, 0); push(CFG, 33, 0);
    step(1'b0, 0, 0, 1'b0, 5'b01000);
    drain();

    cur_req = "R6";
    push(CFG, 40, 1); push(SRD, 41, 1); push(CPL, 42, 1);
    step(1'b0, 0, 0, 1'b1, 5'b10000);
    push(PW, 43, 1); push(CPL, 44, 1);
    step(1'b0, 0, 0, 1'b1, 5'b10000);
    drain();

    cur_req = "R7";
    step(1'b1, DRD, 50, 1'b1, 5'b0);
    step(1'b1, SRD, 51, 1'b0, 5'b0);
    step(1'b1, 5, 52, 1'b0, 5'b0);
    step(1'b1, 7, 53, 1'b1, 5'b0);
    step(1'b1, SRD, 54, 1'b1, 5'b0);
    step(1'b1, DRD, 55, 1'b0, 5'b0);
    drain();

    cur_req = "R8";
    push(CFG, 60, 0); push(CFG, 61, 0);
    step(1'b1, CFG, 62, 1'b0, 5'b01000);
    step(1'b1, CFG, 63, 1'b0, 5'b0);
    drain();

    cur_req = "R10";
    for (int k = 0; k < 9; k++) push(PW, 70 + k, 0);
    push(CPL, 90, 0);
    step(1'b1, CPL, 91, 1'b0, 5'b10001);
    for (int k = 0; k < 4; k++) step(1'b1, PW, 100 + k, 1'b0, 5'b00001);
    drain();
    push(CPL, 110, 0); push(DRD, 111, 0); push(CPL, 112, 0); push(DRD, 113, 0);
    step(1'b0, 0, 0, 1'b0, 5'b00010);
    step(1'b0, 0, 0, 1'b0, 5'b10000);
    drain();

    cur_req = "R9";
    for (int k = 0; k < 3000; k++)
      step(1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 5)),
           int'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
           5'($urandom_range(0, 31)));
    drain();
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule